// File: doc/BRIEF.md
# Completion Queue Interrupt Controller

This block keeps two first-in first-out queues of packet numbers. One queue holds transmit completions and the other holds receive completions. The dynamic interrupt status bits follow the occupancy of these queues. The block merges them with latched event bits and an 8-bit mask, and drives one registered interrupt line. The host reaches the queues through single-cycle command strobes:

- enqueue a transmit packet number (only while transmit is enabled);
- pop the transmit head;
- pop the receive head, with or without releasing its packet.

The host acknowledges interrupt bits by writing ones to the interrupt register, and loads the mask in the same write.

The block also forms the read value of the queue-heads word. The low byte carries the transmit head and the high byte carries the receive head. Either byte reads 0x80 when its queue is empty. A receive pop that releases its packet presents the popped packet number on a release output in the same cycle, for the buffer allocator to reclaim. Frame timing is outside the block: a completion strobe from the transmitter marks a sent frame.

Top module: `cqic_top`

## Requirements
- R1: The interrupt line `irq_o` (active high by default) rises or falls one clock after the masked status `irq_reg[15:8] & irq_reg[7:0]` becomes nonzero or zero, respectively.
- R2: Status bit 2 (`irq_reg[2]`, transmit-queue-empty) is 1 exactly when the transmit completion queue holds no entry.
- R3: Status bit 0 (`irq_reg[0]`, receive pending) is 1 exactly when the receive completion queue holds at least one entry.
- R4: A strobe on `irq_we` loads `irq_wdata[15:8]` into the mask, which `irq_reg[15:8]` shows from the next cycle. In the same write, each latched status bit whose `irq_wdata[7:0]` bit is 1 and lies within the clear mask 0x56 is cleared; other status bits keep their value.
- R5: A write with `irq_wdata[1]`=1 while status bit 1 (transmit done) is set also pops the transmit queue head. The same write made while bit 1 is clear pops nothing. `tx_pop` pops the transmit head unconditionally.
- R6: `fifo_ports[7:0]` shows the transmit head packet number, or 0x80 if that queue is empty. `fifo_ports[15:8]` shows the receive head in the same way.
- R7: `enq_valid` pushes `enq_pkt` into the transmit queue only while `tx_en` is 1; otherwise the queue is unchanged.
- R8: `tx_done` sets status bit 1. `evt_set` sets the latched status bits 1 and 3 to 7; its bits 0 and 2 have no effect. When a bit is set and cleared in the same cycle, the set wins.
- R9: `rx_pop_rel` on a nonempty receive queue asserts `rel_valid` with `rel_pkt` equal to the head in that cycle, then pops the head. `rx_pop` pops the head without asserting `rel_valid`.
- R10: Each queue keeps first-in first-out order with DEPTH entries. A pop of an empty queue is ignored. A push to a queue that was full at the start of the cycle is ignored.
- R11: After reset both queues are empty, the mask and the latched status bits are 0, `irq_o` is inactive, `irq_reg` reads 0x0004 and `fifo_ports` reads 0x8080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; gates enqueue |
| enq_valid | input | 1 | Enqueue strobe for the transmit queue |
| enq_pkt | input | PKT_W | Packet number to enqueue |
| tx_done | input | 1 | Frame-sent strobe; sets status bit 1 |
| tx_pop | input | 1 | Remove-transmit-head command |
| rx_push_valid | input | 1 | Receive completion strobe |
| rx_push_pkt | input | PKT_W | Received packet number |
| rx_pop | input | 1 | Remove-receive-head command |
| rx_pop_rel | input | 1 | Remove-and-release-receive-head command |
| evt_set | input | 8 | Set strobes for latched status bits |
| irq_we | input | 1 | Interrupt register write strobe |
| irq_wdata | input | 16 | Write data: mask in high byte, acknowledge ones in low byte |
| irq_reg | output | 16 | Interrupt register read value: mask and status |
| fifo_ports | output | 16 | Queue heads read value |
| rel_valid | output | 1 | A packet is released this cycle |
| rel_pkt | output | PKT_W | Released packet number |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with DEPTH=6 and PKT_W=4. The queue depth is not a power of two, so the compare-and-wrap pointer variant is the one exercised. The short queues fill within a few random cycles, which brings push-when-full and pop-when-empty within reach of the random phase as well as the directed fills. With four-bit packet numbers, a head value can never collide with the 0x80 empty marker. The reference model tracks every status bit, so the masked interrupt, the acknowledge-pop and the set-over-clear rule are checked in the same cycles where the queues change.

// File: rtl/cqic_pkg.sv
package cqic_pkg;
   localparam int STAT_W       = 8;
   localparam int BIT_RXPEND   = 0;
   localparam int BIT_TXDONE   = 1;
   localparam int BIT_TXEMPTY  = 2;
   localparam logic [7:0] ACK_CLR_MASK = 8'h56;
   localparam logic [7:0] DYN_MASK     = 8'h05;
   localparam logic [7:0] EMPTY_CODE   = 8'h80;

   typedef struct packed {
      logic push;
      logic pop;
   } q_cmd_t;
endpackage

// File: rtl/cqic_fifo.sv
module cqic_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cqic_pkg::q_cmd_t cmd,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_q, wr_q, rd_inc, wr_inc;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign do_push = cmd.push && !full;
   assign do_pop  = cmd.pop && !empty;
   assign head    = mem[rd_q];

   generate
      if (POW2) begin : g_wrap_nat
         assign rd_inc = rd_q + 1'b1;
         assign wr_inc = wr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_inc = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_inc = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_inc;
         if (do_pop)  rd_q <= rd_inc;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din;
   end
endmodule

// File: rtl/cqic_status.sv
module cqic_status
   import cqic_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        irq_we,
   input  logic [15:0] irq_wdata,
   input  logic        tx_done,
   input  logic [7:0]  evt_set,
   input  logic        tx_empty,
   input  logic        rx_nonempty,
   output logic [7:0]  status,
   output logic [7:0]  mask,
   output logic        tx_ack_pop
);
   logic [7:0] lat_q, lat_d, clr_v, set_v;

   assign clr_v = irq_we ? (irq_wdata[7:0] & ACK_CLR_MASK) : 8'h00;
   assign set_v = (evt_set & ~DYN_MASK) | (8'(tx_done) << BIT_TXDONE);
   assign tx_ack_pop = irq_we && irq_wdata[BIT_TXDONE] && lat_q[BIT_TXDONE];

   always_comb begin
      lat_d = ((lat_q & ~clr_v) | set_v) & ~DYN_MASK;
   end

   always_comb begin
      status = lat_q;
      status[BIT_RXPEND]  = rx_nonempty;
      status[BIT_TXEMPTY] = tx_empty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= 8'h00;
         mask  <= 8'h00;
      end else begin
         lat_q <= lat_d;
         if (irq_we) mask <= irq_wdata[15:8];
      end
   end
endmodule

// File: rtl/cqic_irq_out.sv
module cqic_irq_out #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] status,
   input  logic [7:0] mask,
   output logic       irq_o
);
   logic hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= |(status & mask);
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign irq_o = ~hit_q;
      end else begin : g_high
         assign irq_o = hit_q;
      end
   endgenerate
endmodule

// File: rtl/cqic_top.sv
module cqic_top
   import cqic_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int PKT_W      = 4,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             enq_valid,
   input  logic [PKT_W-1:0] enq_pkt,
   input  logic             tx_done,
   input  logic             tx_pop,
   input  logic             rx_push_valid,
   input  logic [PKT_W-1:0] rx_push_pkt,
   input  logic             rx_pop,
   input  logic             rx_pop_rel,
   input  logic [7:0]       evt_set,
   input  logic             irq_we,
   input  logic [15:0]      irq_wdata,
   output logic [15:0]      irq_reg,
   output logic [15:0]      fifo_ports,
   output logic             rel_valid,
   output logic [PKT_W-1:0] rel_pkt,
   output logic             irq_o
);
   generate
      if (PKT_W < 1 || PKT_W > 7) begin : g_bad_pkt_w
         $error("PKT_W must lie in 1..7 so a head never equals the empty code");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   q_cmd_t           tx_cmd, rx_cmd;
   logic [PKT_W-1:0] tx_head, rx_head;
   logic             tx_empty, tx_full, rx_empty, rx_full;
   logic             tx_ack_pop;
   logic [7:0]       status, mask;

   assign tx_cmd.push = enq_valid && tx_en;
   assign tx_cmd.pop  = tx_pop || tx_ack_pop;
   assign rx_cmd.push = rx_push_valid;
   assign rx_cmd.pop  = rx_pop || rx_pop_rel;

   cqic_fifo #(.DEPTH(DEPTH), .W(PKT_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .cmd(tx_cmd), .din(enq_pkt),
      .head(tx_head), .empty(tx_empty), .full(tx_full)
   );

   cqic_fifo #(.DEPTH(DEPTH), .W(PKT_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .cmd(rx_cmd), .din(rx_push_pkt),
      .head(rx_head), .empty(rx_empty), .full(rx_full)
   );

   cqic_status u_stat (
      .clk(clk), .rst_n(rst_n), .irq_we(irq_we), .irq_wdata(irq_wdata),
      .tx_done(tx_done), .evt_set(evt_set), .tx_empty(tx_empty),
      .rx_nonempty(!rx_empty), .status(status), .mask(mask),
      .tx_ack_pop(tx_ack_pop)
   );

   cqic_irq_out #(.ACTIVE_LOW(ACTIVE_LOW)) u_irq (
      .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .irq_o(irq_o)
   );

   assign irq_reg    = {mask, status};
   assign fifo_ports = {rx_empty ? EMPTY_CODE : 8'(rx_head),
                        tx_empty ? EMPTY_CODE : 8'(tx_head)};
   assign rel_valid  = rx_pop_rel && !rx_empty;
   assign rel_pkt    = rx_head;

   logic unused_full;
   assign unused_full = tx_full ^ rx_full;
endmodule

// File: rtl/cqic_chk.sv
module cqic_chk #(
   parameter int PKT_W      = 4,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_en,
   input logic             enq_valid,
   input logic             tx_done,
   input logic             tx_pop,
   input logic             irq_we,
   input logic [15:0]      irq_wdata,
   input logic [15:0]      irq_reg,
   input logic [15:0]      fifo_ports,
   input logic             rel_valid,
   input logic [PKT_W-1:0] rel_pkt,
   input logic             irq_o
);
   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o ^ ACTIVE_LOW) == $past(|(irq_reg[15:8] & irq_reg[7:0]))); // R1
   AST_TXEMPTY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_reg[2] == (fifo_ports[7:0] == 8'h80)); // R2
   AST_RXPEND_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_reg[0] == (fifo_ports[15:8] != 8'h80)); // R3
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_we |=> irq_reg[15:8] == $past(irq_wdata[15:8])); // R4
   AST_TXEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && enq_valid && !tx_pop && !(irq_we && irq_wdata[1] && irq_reg[1]))
      |=> $stable(fifo_ports[7:0])); // R7
   AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> irq_reg[1]); // R8
   AST_REL_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> (8'(rel_pkt) == fifo_ports[15:8])); // R9
endmodule

bind cqic_top cqic_chk #(.PKT_W(PKT_W), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .enq_valid(enq_valid),
   .tx_done(tx_done), .tx_pop(tx_pop), .irq_we(irq_we), .irq_wdata(irq_wdata),
   .irq_reg(irq_reg), .fifo_ports(fifo_ports), .rel_valid(rel_valid),
   .rel_pkt(rel_pkt), .irq_o(irq_o)
);

// File: tb/sim_cqic_top.sv
module sim_cqic_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 6;
   localparam int PKT_W      = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 0, enq_valid = 0, tx_done = 0, tx_pop = 0;
   logic rx_push_valid = 0, rx_pop = 0, rx_pop_rel = 0, irq_we = 0;
   logic [PKT_W-1:0] enq_pkt = '0, rx_push_pkt = '0;
   logic [7:0]  evt_set = 8'h00;
   logic [15:0] irq_wdata = 16'h0000;
   logic [15:0] irq_reg, fifo_ports;
   logic        rel_valid, irq_o;
   logic [PKT_W-1:0] rel_pkt;

   int n_checks = 0;
   int n_errors = 0;

   logic [7:0] m_txq [DEPTH];
   logic [7:0] m_rxq [DEPTH];
   int m_txn = 0, m_rxn = 0;
   logic [7:0] m_mask = 8'h00, m_lat = 8'h00;
   logic m_irq = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cqic_top #(.DEPTH(DEPTH), .PKT_W(PKT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .enq_valid(enq_valid),
      .enq_pkt(enq_pkt), .tx_done(tx_done), .tx_pop(tx_pop),
      .rx_push_valid(rx_push_valid), .rx_push_pkt(rx_push_pkt),
      .rx_pop(rx_pop), .rx_pop_rel(rx_pop_rel), .evt_set(evt_set),
      .irq_we(irq_we), .irq_wdata(irq_wdata), .irq_reg(irq_reg),
      .fifo_ports(fifo_ports), .rel_valid(rel_valid), .rel_pkt(rel_pkt),
      .irq_o(irq_o)
   );

   function automatic logic [7:0] m_status();
      logic [7:0] s;
      s = m_lat;
      s[0] = (m_rxn != 0);
      s[2] = (m_txn == 0);
      return s;
   endfunction

   function automatic logic [7:0] head_code(input int n, input logic [7:0] h);
      return (n == 0) ? 8'h80 : h;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_state(input string ftag);
      logic [7:0] s;
      s = m_status();
      chk("R1 irq line", 16'(irq_o), 16'(m_irq));
      chk("R2 tx-empty bit", 16'(irq_reg[2]), 16'(s[2]));
      chk("R3 rx-pending bit", 16'(irq_reg[0]), 16'(s[0]));
      chk("R5 tx-done bit", 16'(irq_reg[1]), 16'(s[1]));
      chk("R8 event bits", 16'(irq_reg[7:3]), 16'(s[7:3]));
      chk("R4 mask", 16'(irq_reg[15:8]), 16'(m_mask));
      chk({ftag, " tx head"}, 16'(fifo_ports[7:0]), 16'(head_code(m_txn, m_txq[0])));
      chk({ftag, " rx head"}, 16'(fifo_ports[15:8]), 16'(head_code(m_rxn, m_rxq[0])));
   endtask

   task automatic q_pop(ref logic [7:0] q [DEPTH], ref int n);
      for (int i = 0; i < DEPTH - 1; i++) q[i] = q[i+1];
      n--;
   endtask

   // drive one cycle of inputs, check same-cycle release, advance the model
   task automatic step(input logic en, input logic enq, input logic [PKT_W-1:0] ep,
                       input logic done, input logic tpop, input logic rpush,
                       input logic [PKT_W-1:0] rp, input logic rpop, input logic rrel,
                       input logic [7:0] ev, input logic we, input logic [15:0] wd,
                       input string ftag);
      logic irq_n, tpush_ok, tpop_ok, rpush_ok, rpop_ok, ackpop;
      logic [7:0] clr, set;
      tx_en = en; enq_valid = enq; enq_pkt = ep; tx_done = done; tx_pop = tpop;
      rx_push_valid = rpush; rx_push_pkt = rp; rx_pop = rpop; rx_pop_rel = rrel;
      evt_set = ev; irq_we = we; irq_wdata = wd;
      #1;
      chk("R9 release valid", 16'(rel_valid), 16'(rrel && (m_rxn > 0)));
      if (rrel && m_rxn > 0) chk("R9 release pkt", 16'(rel_pkt), 16'(m_rxq[0]));
      irq_n    = |(m_mask & m_status());
      ackpop   = we && wd[1] && m_lat[1];
      tpush_ok = enq && en && (m_txn < DEPTH);
      tpop_ok  = (tpop || ackpop) && (m_txn > 0);
      rpush_ok = rpush && (m_rxn < DEPTH);
      rpop_ok  = (rpop || rrel) && (m_rxn > 0);
      if (tpop_ok) q_pop(m_txq, m_txn);
      if (tpush_ok) begin m_txq[m_txn] = 8'(ep); m_txn++; end
      if (rpop_ok) q_pop(m_rxq, m_rxn);
      if (rpush_ok) begin m_rxq[m_rxn] = 8'(rp); m_rxn++; end
      clr   = we ? (wd[7:0] & 8'h56) : 8'h00;
      set   = (ev & 8'hFA) | (done ? 8'h02 : 8'h00);
      m_lat = ((m_lat & ~clr) | set) & 8'hFA;
      if (we) m_mask = wd[15:8];
      m_irq = irq_n;
      @(negedge clk);
      compare_state(ftag);
   endtask

   task automatic idle(input string ftag);
      step(0, 0, '0, 0, 0, 0, '0, 0, 0, 8'h00, 0, 16'h0, ftag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 irq_reg", irq_reg, 16'h0004);
      chk("R11 fifo_ports", fifo_ports, 16'h8080);
      chk("R11 irq", 16'(irq_o), 16'h0);

      // R7: enqueue ignored while transmit disabled
      for (int i = 0; i < 3; i++) step(0, 1, PKT_W'(i+1), 0, 0, 0, '0, 0, 0, 8'h00, 0, 16'h0, "R7");
      // R10: fill past full, then check order on drain
      for (int i = 0; i < DEPTH + 2; i++)
         step(1, 1, PKT_W'(i + 3), 0, 0, 0, '0, 0, 0, 8'h00, 0, 16'h0, "R10");
      // R5: acknowledge without tx-done status pops nothing
      step(1, 0, '0, 0, 0, 0, '0, 0, 0, 8'h00, 1, 16'h0002, "R5");
      step(1, 0, '0, 1, 0, 0, '0, 0, 0, 8'h00, 0, 16'h0, "R5");
      step(1, 0, '0, 0, 0, 0, '0, 0, 0, 8'h00, 1, 16'h0002, "R5");
      // R8: set wins over simultaneous clear
      step(1, 0, '0, 1, 0, 0, '0, 0, 0, 8'h50, 1, 16'h0056, "R8");
      for (int i = 0; i < DEPTH + 2; i++)
         step(1, 0, '0, 0, 1, 0, '0, 0, 0, 8'h00, 0, 16'h0, "R10");
      // R9: release versus plain pop
      for (int i = 0; i < 3; i++) step(1, 0, '0, 0, 0, 1, PKT_W'(9 + i), 0, 0, 8'h00, 0, 16'h0, "R9");
      step(1, 0, '0, 0, 0, 0, '0, 0, 1, 8'h00, 0, 16'h0, "R9");
      step(1, 0, '0, 0, 0, 0, '0, 1, 0, 8'h00, 0, 16'h0, "R9");
      step(1, 0, '0, 0, 0, 0, '0, 1, 1, 8'h00, 0, 16'h0, "R9");
      step(1, 0, '0, 0, 0, 0, '0, 0, 1, 8'h00, 0, 16'h0, "R9");
      // R1/R4: mask on tx-empty, irq follows one cycle later
      step(1, 0, '0, 0, 0, 0, '0, 0, 0, 8'h00, 1, 16'h0400, "R6");
      idle("R6");
      step(1, 0, '0, 0, 0, 0, '0, 0, 0, 8'h00, 1, 16'h0000, "R6");
      idle("R6");

      // constrained random phase
      for (int c = 0; c < 4000; c++) begin
         logic [15:0] wd;
         wd = 16'($urandom);
         step(($urandom % 8) != 0, ($urandom % 3) == 0, PKT_W'($urandom),
              ($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
              PKT_W'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0,
              (($urandom % 8) == 0) ? 8'($urandom) : 8'h00,
              ($urandom % 5) == 0, wd, "R6");
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule